// File: doc/BRIEF.md
# Multimode Test Register

This block is a row of flip-flops that one pair of mode pins turns into four different machines. It can be a plain parallel register that captures a word. It can be a scan chain that shifts one bit per clock. It can be a register that clears itself synchronously. It can also be a multiple-input signature register (MISR), which folds a stream of parallel response words into a signature. In MISR mode, if the parallel inputs are held at a constant value, the same flip-flops step through a pseudorandom sequence. The block can therefore generate test patterns for the logic that follows it, or compact the responses of the logic in front of it.

The mode pins are sampled on every rising clock edge, so a change of mode takes effect on the next edge with no latency. The feedback into the first stage is the XOR of the stages that a tap-mask parameter selects. The default mask describes the primitive polynomial x^8 + x^6 + x^5 + x^4 + 1 for the default width of 8. The state is visible at all times as true and complemented parallel words and as a serial output. Parallel data has no handshake: a word is taken on every edge in the capture and MISR modes.

Top module: `multimode_test_reg`

## Requirements
- R1: While `rst_n` is low, every stage is 0 (asynchronous, active-low reset).
- R2: With `cfg_par`=0 and `cfg_keep`=1 (clear mode), every stage becomes 0 on the next rising edge, whatever `par_in` and `scan_in` are.
- R3: With `cfg_par`=1 and `cfg_keep`=1 (capture mode), stage i takes `par_in[i]` on the next rising edge, for every i.
- R4: With `cfg_par`=0 and `cfg_keep`=0 (scan mode), stage 0 takes `scan_in` and stage i takes the old stage i-1 on each rising edge. `par_in` is ignored, and `q_out` shows the contents after every shift.
- R5: With `cfg_par`=1 and `cfg_keep`=0 (MISR mode), stage i (i>0) takes `par_in[i]` XOR old stage i-1, and stage 0 takes `par_in[0]` XOR the feedback bit. The feedback bit is the XOR of the stages i for which bit i of `TAP_MASK` is 1, and bit i of the mask stands for the term x^(i+1).
- R6: In MISR mode with `par_in` held at 0 and the default mask, a nonzero state returns to itself after exactly 2^WIDTH-1 = 255 edges and not earlier, and it never becomes zero.
- R7: `q_n_out` is the bitwise complement of `q_out` at all times.
- R8: `scan_out` equals the last stage, `q_out[WIDTH-1]`, in every mode.
- R9: A change on the mode pins takes effect on the first rising edge at which the new value is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_par | input | 1 | Mode select, high bit: 1 selects the modes that use the parallel inputs |
| cfg_keep | input | 1 | Mode select, low bit |
| par_in | input | WIDTH | Parallel data or response word, bit i feeds stage i |
| scan_in | input | 1 | Serial input into stage 0 |
| q_out | output | WIDTH | True outputs of the stages |
| q_n_out | output | WIDTH | Complemented outputs of the stages |
| scan_out | output | 1 | Serial output, the last stage |

## Verification
The assertions check the next-state rule of each mode on every edge: clear, capture, the shift by one stage, and the MISR update of the upper stages. They also check the complement and serial outputs in every cycle. The feedback value and whether the tap mask gives a maximal sequence can only be shown by the bench. It compares signatures over random response streams against an independent model, and it counts the period of the free-running generator. The bench also walks through mode changes in sequence to show that each one takes effect on the next edge.

// File: rtl/mmtr_pkg.sv
package mmtr_pkg;
  // Mode code = {cfg_par, cfg_keep}
  typedef enum logic [1:0] {
    MD_SCAN  = 2'b00,
    MD_CLEAR = 2'b01,
    MD_MISR  = 2'b10,
    MD_LOAD  = 2'b11
  } mmtr_mode_t;
endpackage

// File: rtl/mmtr_mode_dec.sv
module mmtr_mode_dec
  import mmtr_pkg::*;
(
  input  logic       sel_hi,
  input  logic       sel_lo,
  output mmtr_mode_t mode
);
  always_comb begin
    unique case ({sel_hi, sel_lo})
      2'b00:   mode = MD_SCAN;
      2'b01:   mode = MD_CLEAR;
      2'b10:   mode = MD_MISR;
      default: mode = MD_LOAD;
    endcase
  end
endmodule

// File: rtl/mmtr_feedback.sv
module mmtr_feedback #(
  parameter int unsigned   WIDTH    = 8,
  parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb
);
  logic [WIDTH-1:0] tapped;
  assign tapped = state & TAP_MASK;
  assign fb     = ^tapped;
endmodule

// File: rtl/mmtr_next.sv
module mmtr_next
  import mmtr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  mmtr_mode_t       mode,
  input  logic [WIDTH-1:0] state,
  input  logic [WIDTH-1:0] par_in,
  input  logic             scan_in,
  input  logic             fb,
  output logic [WIDTH-1:0] nxt
);
  // value entering each stage from its upstream neighbour
  logic [WIDTH-1:0] upstream;

  always_comb begin
    upstream[0] = (mode == MD_MISR) ? fb : scan_in;
  end

  for (genvar i = 1; i < WIDTH; i++) begin : g_up
    assign upstream[i] = state[i-1];
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    always_comb begin
      unique case (mode)
        MD_CLEAR: nxt[i] = 1'b0;
        MD_LOAD:  nxt[i] = par_in[i];
        MD_SCAN:  nxt[i] = upstream[i];
        default:  nxt[i] = upstream[i] ^ par_in[i];
      endcase
    end
  end
endmodule

// File: rtl/multimode_test_reg.sv
module multimode_test_reg
  import mmtr_pkg::*;
#(
  parameter int unsigned      WIDTH    = 8,
  parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_par,
  input  logic             cfg_keep,
  input  logic [WIDTH-1:0] par_in,
  input  logic             scan_in,
  output logic [WIDTH-1:0] q_out,
  output logic [WIDTH-1:0] q_n_out,
  output logic             scan_out
);
  localparam int unsigned LAST = WIDTH - 1;

  mmtr_mode_t       mode;
  logic             fb;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  mmtr_mode_dec u_dec (
    .sel_hi (cfg_par),
    .sel_lo (cfg_keep),
    .mode   (mode)
  );

  mmtr_feedback #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_fb (
    .state (state_q),
    .fb    (fb)
  );

  mmtr_next #(.WIDTH(WIDTH)) u_next (
    .mode    (mode),
    .state   (state_q),
    .par_in  (par_in),
    .scan_in (scan_in),
    .fb      (fb),
    .nxt     (state_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign q_out    = state_q;
  assign q_n_out  = ~state_q;
  assign scan_out = state_q[LAST];

  // R1 / R7 / R8: output relations
  always_comb begin
    if (!rst_n) a_r1_reset_zero: assert (q_out == '0);
    a_r7_complement: assert (q_n_out == ~q_out);
    a_r8_serial_last: assert (scan_out == q_out[LAST]);
  end

  // R2, R9
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_par && cfg_keep) |=> (q_out == '0));

  // R3, R9
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_par && cfg_keep) |=> (q_out == $past(par_in)));

  // R4, R9
  a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_par && !cfg_keep) |=>
      (q_out[0] == $past(scan_in)) && (q_out[LAST:1] == $past(q_out[LAST-1:0])));

  // R5: upper stages compact parallel inputs
  a_r5_misr_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_par && !cfg_keep) |=>
      (q_out[LAST:1] == ($past(q_out[LAST-1:0]) ^ $past(par_in[LAST:1]))));
endmodule

// File: tb/multimode_test_reg_test.sv
module multimode_test_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam logic [W-1:0] MASK = 8'hB8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_par = 1'b0, cfg_keep = 1'b1;
  logic [W-1:0] par_in = '0;
  logic scan_in = 1'b0;
  logic [W-1:0] q_out, q_n_out;
  logic scan_out;

  int n_cmp = 0, n_bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  multimode_test_reg #(.WIDTH(W), .TAP_MASK(MASK)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_par(cfg_par), .cfg_keep(cfg_keep),
    .par_in(par_in), .scan_in(scan_in),
    .q_out(q_out), .q_n_out(q_n_out), .scan_out(scan_out)
  );

  function automatic logic [W-1:0] model_misr(logic [W-1:0] s, logic [W-1:0] p);
    logic f;
    f = ^(s & MASK);
    return {s[W-2:0], f} ^ p;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // also checks R7 and R8 whenever outputs are sampled
  task automatic check_state(string req, logic [W-1:0] exp);
    check(req, q_out, exp);
    check("R7", q_n_out, ~exp);
    check("R8", {7'd0, scan_out}, {7'd0, exp[W-1]});
  endtask

  task automatic set_mode(logic p, logic k);
    cfg_par = p; cfg_keep = k;
  endtask

  // one edge; inputs changed and outputs sampled 1 time unit after edge
  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    check_state("R1", '0);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_capture;
    set_mode(1, 1); par_in = 8'hA5; tick; check_state("R3", 8'hA5);
    par_in = 8'h3C; tick; check_state("R3", 8'h3C);
  endtask

  task automatic t_clear;
    set_mode(1, 1); par_in = 8'hFF; tick;
    set_mode(0, 1); par_in = 8'h77; scan_in = 1'b1; tick; check_state("R2", 8'h00);
  endtask

  task automatic t_scan;
    logic [W-1:0] exp;
    logic [7:0] pat;
    set_mode(1, 1); par_in = 8'h81; tick; exp = 8'h81;
    set_mode(0, 0); pat = 8'b0110_1101;
    for (int i = 0; i < 10; i++) begin
      scan_in = pat[i % 8]; par_in = 8'($urandom);
      tick;
      exp = {exp[W-2:0], pat[i % 8]};
      check_state("R4", exp);
    end
  endtask

  task automatic t_misr_streams;
    for (int run = 0; run < 3; run++) begin
      logic [W-1:0] m;
      set_mode(0, 1); tick; m = '0;
      set_mode(1, 0);
      for (int c = 0; c < 40; c++) begin
        par_in = 8'($urandom);
        scan_in = 1'($urandom);
        m = model_misr(m, par_in);
        tick;
        check_state("R5", m);
      end
    end
  endtask

  task automatic t_period;
    int steps;
    logic [W-1:0] m;
    logic zero_seen;
    set_mode(1, 1); par_in = 8'h5B; tick; m = 8'h5B;
    set_mode(1, 0); par_in = '0;
    steps = 0; zero_seen = 1'b0;
    do begin
      tick; steps++;
      m = model_misr(m, '0);
      if (q_out == '0) zero_seen = 1'b1;
    end while (q_out != 8'h5B && steps < 300);
    check("R6 period", 8'(steps), 8'd255);
    check("R6 no zero", {7'd0, zero_seen}, 8'd0);
    check("R6 model", q_out, m);
  endtask

  task automatic t_transitions;
    logic [W-1:0] e;
    set_mode(1, 1); par_in = 8'hC3; tick; check_state("R9 load", 8'hC3);
    set_mode(1, 0); par_in = 8'h0F; tick;
    e = model_misr(8'hC3, 8'h0F); check_state("R9 misr", e);
    set_mode(0, 0); scan_in = 1'b1; tick;
    e = {e[W-2:0], 1'b1}; check_state("R9 scan", e);
    set_mode(0, 1); tick; check_state("R9 clear", 8'h00);
    set_mode(0, 0); scan_in = 1'b1; tick; check_state("R9 scan2", 8'h01);
    set_mode(1, 1); par_in = 8'h80; tick; check_state("R9 load2", 8'h80);
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset;
    t_capture;
    t_clear;
    t_scan;
    t_misr_streams;
    t_period;
    t_transitions;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule